// File: doc/BRIEF.md
# Dual-Polarization Stokes Calculator

This block turns a stream of complex spectral samples from two orthogonal polarization channels into the four Stokes terms I, Q, U and V. It handles one frequency channel per clock. Each clock it accepts the real and imaginary parts of both polarizations, a valid flag, an 8-bit channel index and a bypass select. The block sits between a spectrum source and downstream folding or integration logic. Channels normally arrive in ascending order, 0 to 255, and the order repeats for every spectrum.

Every real or imaginary part is a 9-bit sign-magnitude word. The block forms each cross or square product as an unsigned magnitude product, keeps the top bits of that product, and applies the XOR of the two operand signs. A pipelined adder/subtractor then combines the products. In bypass mode the four outputs carry the raw input words instead of the computed terms. The bypass select is captured with each sample, so a stream can switch modes from one sample to the next.

Top module: `stokes_calc`

## Requirements
- R1: While rst_n is low, and until the first sample reaches the output, out_valid, out_chan and all four result outputs are zero.
- R2: Operand words are sign-magnitude. Bit 8 is the sign (1 = negative) and bits 7:0 are the magnitude. A word with the sign set and magnitude zero behaves exactly like zero.
- R3: With e1 = a + jb and e2 = c + jd, the output stokes_i equals a² + b² + c² + d².
- R4: stokes_q equals (a² + b²) − (c² + d²).
- R5: stokes_u equals 2·(a·c + b·d), the doubled real part of e1·conj(e2).
- R6: stokes_v equals 2·(b·c − a·d), the doubled imaginary part of e1·conj(e2).
- R7: A sample sampled at clock edge n shows its results after edge n+3. Back-to-back samples are accepted on every clock with no stall.
- R8: out_valid and out_chan are in_valid and in_chan delayed by the same latency as the results, so they stay aligned with them.
- R9: When bypass_en is high with a sample, that sample's outputs are its raw 9-bit words, zero-extended. stokes_i carries e1_re, stokes_q carries e1_im, stokes_u carries e2_re and stokes_v carries e2_im. Neighbouring samples are unaffected.
- R10: Results are 20-bit two's complement and never overflow. With every magnitude at 255, stokes_i is 260100.
- R11: Each product magnitude is reduced to its upper 16 bits before it is summed. With 8-bit magnitudes this keeps the full product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is valid |
| in_chan | input | 8 | Frequency channel index of the input sample |
| bypass_en | input | 1 | Forward raw words for this sample |
| e1_re | input | 9 | Polarization 1, real part, sign-magnitude |
| e1_im | input | 9 | Polarization 1, imaginary part, sign-magnitude |
| e2_re | input | 9 | Polarization 2, real part, sign-magnitude |
| e2_im | input | 9 | Polarization 2, imaginary part, sign-magnitude |
| out_valid | output | 1 | Result is valid |
| out_chan | output | 8 | Channel index of the result |
| stokes_i | output | 20 | Total power, or raw e1_re in bypass |
| stokes_q | output | 20 | Power difference, or raw e1_im in bypass |
| stokes_u | output | 20 | Doubled real cross term, or raw e2_re in bypass |
| stokes_v | output | 20 | Doubled imaginary cross term, or raw e2_im in bypass |

## Verification
Purely real and purely imaginary operands are applied first. Each of these zeroes one of the two cross products, so a swapped operand pairing in U or V shows up on its own. Mixed-sign operands and negative-zero words test the XOR sign path separately from the magnitude path. All-255 operands in every sign combination probe the widest sums. A full 256-channel sweep of random words runs back to back, with valid gaps and bypass toggling mid-stream. This shows that the sideband and the per-sample mode select stay aligned with the data.

// File: rtl/stokes_pkg.sv
package stokes_pkg;
    localparam int MAG_W      = 8;             // operand magnitude bits
    localparam int SM_W       = MAG_W + 1;     // sign-magnitude word
    localparam int KEEP_W     = 16;            // retained product magnitude bits
    localparam int CHAN_W     = 8;             // channel index width
    localparam int PIPE_DEPTH = 4;             // register stages input to output
    localparam int PROD_W     = KEEP_W + 1;    // signed product
    localparam int SUM_W      = KEEP_W + 2;    // signed pair sum
    localparam int OUT_W      = KEEP_W + 4;    // signed result
    localparam int N_OPS      = 4;
    localparam int N_PROD     = 8;

    typedef logic [SM_W-1:0]          sm_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [OUT_W-1:0]  out_t;
endpackage

// File: rtl/stokes_sm_mul.sv
module stokes_sm_mul
    import stokes_pkg::*;
(
    input  sm_t   a_i,
    input  sm_t   b_i,
    output prod_t p_o
);
    logic [2*MAG_W-1:0] full_mag;
    logic [KEEP_W-1:0]  kept_mag;
    logic               neg;

    always_comb begin
        full_mag = a_i[MAG_W-1:0] * b_i[MAG_W-1:0];
        kept_mag = full_mag[2*MAG_W-1 -: KEEP_W];
        neg      = a_i[MAG_W] ^ b_i[MAG_W];
        p_o      = neg ? -$signed({1'b0, kept_mag}) : $signed({1'b0, kept_mag});
    end
endmodule

// File: rtl/stokes_sideband.sv
module stokes_sideband #(
    parameter int DEPTH  = 4,
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              byp_i,
    output logic              valid_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic [DEPTH-2:0]  byp_tap_o
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-2:0]             byp;
        logic [DEPTH-1:0][CHAN_W-1:0] chan;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d      = sb_q;
        sb_d.vld  = {sb_q.vld[DEPTH-2:0], valid_i};
        sb_d.chan = {sb_q.chan[DEPTH-2:0], chan_i};
        if (DEPTH > 2) begin
            sb_d.byp = {sb_q.byp[DEPTH-3:0], byp_i};
        end else begin
            sb_d.byp = byp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign valid_o   = sb_q.vld[DEPTH-1];
    assign chan_o    = sb_q.chan[DEPTH-1];
    assign byp_tap_o = sb_q.byp;
endmodule

// File: rtl/stokes_calc.sv
module stokes_calc
    import stokes_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              bypass_en,
    input  logic [SM_W-1:0]   e1_re,
    input  logic [SM_W-1:0]   e1_im,
    input  logic [SM_W-1:0]   e2_re,
    input  logic [SM_W-1:0]   e2_im,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic [OUT_W-1:0]  stokes_i,
    output logic [OUT_W-1:0]  stokes_q,
    output logic [OUT_W-1:0]  stokes_u,
    output logic [OUT_W-1:0]  stokes_v
);
    // operand order: 0 e1 real, 1 e1 imag, 2 e2 real, 3 e2 imag
    // product order: aa bb cc dd ac bd bc ad
    localparam int LHS [N_PROD] = '{0, 1, 2, 3, 0, 1, 1, 0};
    localparam int RHS [N_PROD] = '{0, 1, 2, 3, 2, 3, 2, 3};

    typedef struct packed {
        sm_t   [N_OPS-1:0]  raw0;   // stage 0: captured operands
        prod_t [N_PROD-1:0] prod;   // stage 1: signed products
        sm_t   [N_OPS-1:0]  raw1;
        sum_t  [N_OPS-1:0]  sum;    // stage 2: pair sums
        sm_t   [N_OPS-1:0]  raw2;
        out_t  [N_OPS-1:0]  res;    // stage 3: results
    } pipe_t;

    pipe_t                 p_d, p_q;
    prod_t                 prod_w [N_PROD];
    logic [PIPE_DEPTH-2:0] byp_tap;

    for (genvar k = 0; k < N_PROD; k++) begin : g_mul
        stokes_sm_mul u_mul (
            .a_i (p_q.raw0[LHS[k]]),
            .b_i (p_q.raw0[RHS[k]]),
            .p_o (prod_w[k])
        );
    end

    stokes_sideband #(
        .DEPTH  (PIPE_DEPTH),
        .CHAN_W (CHAN_W)
    ) u_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (in_valid),
        .chan_i    (in_chan),
        .byp_i     (bypass_en),
        .valid_o   (out_valid),
        .chan_o    (out_chan),
        .byp_tap_o (byp_tap)
    );

    always_comb begin
        p_d      = p_q;
        p_d.raw0 = {e2_im, e2_re, e1_im, e1_re};

        for (int k = 0; k < N_PROD; k++) begin
            p_d.prod[k] = prod_w[k];
        end
        p_d.raw1 = p_q.raw0;

        p_d.sum[0] = sum_t'($signed(p_q.prod[0])) + sum_t'($signed(p_q.prod[1]));
        p_d.sum[1] = sum_t'($signed(p_q.prod[2])) + sum_t'($signed(p_q.prod[3]));
        p_d.sum[2] = sum_t'($signed(p_q.prod[4])) + sum_t'($signed(p_q.prod[5]));
        p_d.sum[3] = sum_t'($signed(p_q.prod[6])) - sum_t'($signed(p_q.prod[7]));
        p_d.raw2   = p_q.raw1;

        if (byp_tap[PIPE_DEPTH-2]) begin
            for (int k = 0; k < N_OPS; k++) begin
                p_d.res[k] = out_t'(p_q.raw2[k]);
            end
        end else begin
            p_d.res[0] = out_t'($signed(p_q.sum[0])) + out_t'($signed(p_q.sum[1]));
            p_d.res[1] = out_t'($signed(p_q.sum[0])) - out_t'($signed(p_q.sum[1]));
            p_d.res[2] = out_t'($signed(p_q.sum[2])) <<< 1;
            p_d.res[3] = out_t'($signed(p_q.sum[3])) <<< 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign stokes_i = p_q.res[0];
    assign stokes_q = p_q.res[1];
    assign stokes_u = p_q.res[2];
    assign stokes_v = p_q.res[3];
endmodule

// File: rtl/stokes_calc_chk.sv
module stokes_calc_chk
    import stokes_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CHAN_W-1:0] in_chan,
    input logic              bypass_en,
    input logic [SM_W-1:0]   e1_re,
    input logic              out_valid,
    input logic [CHAN_W-1:0] out_chan,
    input logic [OUT_W-1:0]  stokes_i,
    input logic [OUT_W-1:0]  stokes_q
);
    logic [2:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 3'd4) warm <= warm + 3'd1;
    end

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R8
    chan_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4 && out_valid) |-> (out_chan == $past(in_chan, 4)));

    // R9
    bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4 && $past(bypass_en, 4)) |-> (stokes_i == OUT_W'($past(e1_re, 4))));

    // R3
    power_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4 && !$past(bypass_en, 4)) |->
        ($signed(stokes_i) >= 0 && $signed(stokes_i) >= $signed(stokes_q)
         && $signed(stokes_i) >= -$signed(stokes_q)));

    // R4
    parity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4 && !$past(bypass_en, 4)) |-> (stokes_i[0] == stokes_q[0]));
endmodule

bind stokes_calc stokes_calc_chk u_chk (.*);

// File: tb/stokes_calc_test.sv
module stokes_calc_test;
    localparam int MAG  = 8;
    localparam int KEEP = 16;
    localparam int LAT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_chan = '0;
    logic       bypass_en = 1'b0;
    logic [8:0] e1_re = '0, e1_im = '0, e2_re = '0, e2_im = '0;
    logic        out_valid;
    logic [7:0]  out_chan;
    logic [19:0] stokes_i, stokes_q, stokes_u, stokes_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit in_rst = 1;

    int mv [LAT], mc [LAT], mi [LAT], mq [LAT], mu [LAT], mw [LAT];
    bit mb [LAT];

    always #5 clk = ~clk;

    stokes_calc uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .bypass_en(bypass_en), .e1_re(e1_re), .e1_im(e1_im), .e2_re(e2_re),
        .e2_im(e2_im), .out_valid(out_valid), .out_chan(out_chan),
        .stokes_i(stokes_i), .stokes_q(stokes_q), .stokes_u(stokes_u), .stokes_v(stokes_v)
    );

    // R2 R11: sign-magnitude product, upper KEEP bits of the magnitude
    function automatic int mulx(logic [8:0] x, logic [8:0] y);
        int m;
        m = (int'(x[7:0]) * int'(y[7:0])) >>> (2 * MAG - KEEP);
        return (x[8] ^ y[8]) ? -m : m;
    endfunction

    function automatic logic [8:0] sm(int x);
        return (x < 0) ? {1'b1, 8'(-x)} : {1'b0, 8'(x)};
    endfunction

    initial begin
        for (int k = 0; k < LAT; k++) begin
            mv[k] = 0; mc[k] = 0; mi[k] = 0; mq[k] = 0; mu[k] = 0; mw[k] = 0; mb[k] = 0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        in_rst = !rst_n;
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
                mv[k] = 0; mc[k] = 0; mi[k] = 0; mq[k] = 0; mu[k] = 0; mw[k] = 0; mb[k] = 0;
            end
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                mv[k] = mv[k-1]; mc[k] = mc[k-1]; mi[k] = mi[k-1]; mq[k] = mq[k-1];
                mu[k] = mu[k-1]; mw[k] = mw[k-1]; mb[k] = mb[k-1];
            end
            mv[0] = in_valid; mc[0] = in_chan; mb[0] = bypass_en;
            if (bypass_en) begin
                mi[0] = e1_re; mq[0] = e1_im; mu[0] = e2_re; mw[0] = e2_im;
            end else begin
                mi[0] = mulx(e1_re, e1_re) + mulx(e1_im, e1_im) + mulx(e2_re, e2_re) + mulx(e2_im, e2_im);
                mq[0] = mulx(e1_re, e1_re) + mulx(e1_im, e1_im) - mulx(e2_re, e2_re) - mulx(e2_im, e2_im);
                mu[0] = 2 * (mulx(e1_re, e2_re) + mulx(e1_im, e2_im));
                mw[0] = 2 * (mulx(e1_im, e2_re) - mulx(e1_re, e2_im));
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every falling edge; outputs and model settle at the rising edge (R7)
    always @(negedge clk) begin
        if (!done) begin
            chk(in_rst ? "R1 valid" : "R8 valid", int'(out_valid), mv[LAT-1]);
            chk(in_rst ? "R1 chan" : "R8 chan", int'(out_chan), mc[LAT-1]);
            chk(in_rst ? "R1 I" : (mb[LAT-1] ? "R9 I" : "R3 R7 I"), int'($signed(stokes_i)), mi[LAT-1]);
            chk(in_rst ? "R1 Q" : (mb[LAT-1] ? "R9 Q" : "R4 R7 Q"), int'($signed(stokes_q)), mq[LAT-1]);
            chk(in_rst ? "R1 U" : (mb[LAT-1] ? "R9 U" : "R5 R7 U"), int'($signed(stokes_u)), mu[LAT-1]);
            chk(in_rst ? "R1 V" : (mb[LAT-1] ? "R9 V" : "R6 R7 V"), int'($signed(stokes_v)), mw[LAT-1]);
        end
    end

    task automatic put(bit v, int ch, bit b, logic [8:0] a, logic [8:0] bb, logic [8:0] c, logic [8:0] d);
        @(negedge clk);
        in_valid = v; in_chan = 8'(ch); bypass_en = b;
        e1_re = a; e1_im = bb; e2_re = c; e2_im = d;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);          // R1 reset values observed
        rst_n = 1'b1;
        // R3 R4 R5 R6: pure real operands
        put(1, 0, 0, sm(5), sm(0), sm(-7), sm(0));
        // pure imaginary operands
        put(1, 1, 0, sm(0), sm(3), sm(0), sm(-9));
        // mixed operands, each cross product distinct
        put(1, 2, 0, sm(3), sm(-4), sm(6), sm(11));
        put(1, 3, 0, sm(-12), sm(7), sm(-2), sm(-5));
        // R2: negative zero equals zero
        put(1, 4, 0, 9'h100, sm(9), 9'h100, 9'h100);
        put(1, 5, 0, 9'h100, 9'h100, 9'h100, 9'h100);
        // R10 R11: full-scale magnitudes in all sign combinations
        for (int s = 0; s < 16; s++) begin
            put(1, 6 + s, 0, {s[0], 8'd255}, {s[1], 8'd255}, {s[2], 8'd255}, {s[3], 8'd255});
        end
        // R8: valid gap, chan keeps flowing
        put(0, 77, 0, sm(1), sm(2), sm(3), sm(4));
        put(0, 78, 0, sm(-1), sm(2), sm(3), sm(-4));
        // R9: bypass single sample between computed ones
        put(1, 30, 1, sm(-100), sm(200), sm(17), 9'h1FF);
        put(1, 31, 0, sm(-100), sm(200), sm(17), 9'h1FF);
        // R7 R9: 256-channel back-to-back sweep, random words, bypass toggling
        for (int ch = 0; ch < 256; ch++) begin
            put(($urandom % 8) != 0, ch, ($urandom % 5) == 0,
                9'($urandom), 9'($urandom), 9'($urandom), 9'($urandom));
        end
        put(0, 0, 0, '0, '0, '0, '0);
        repeat (LAT + 2) @(negedge clk);
        // R1: reset mid-stream clears outputs
        put(1, 9, 0, sm(50), sm(60), sm(70), sm(80));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule